// File: doc/BRIEF.md
# Configurable PLD Output Macrocell Array

This block is the output stage of a small programmable logic device. A row of eight output cells sits between the AND/OR array and the package pins. Each cell receives a sum-of-products value and one product term meant as an output enable. It drives a pin value with a tri-state enable, and it returns a feedback bit to the array. One global mode applies to every cell. The mode is chosen by two global configuration bits, `cfg_syn` and `cfg_ac0`, and it is one of three: simple, complex or registered. Each cell adds two bits of its own. `cfg_xor[i]` sets the output polarity, and `cfg_ac1[i]` picks the cell's input/output role within the mode.

The decoded global mode behaves like a state: MODE_SIMPLE, MODE_COMPLEX or MODE_REGISTERED. Changing the configuration bits is the only transition. Any mode can move to any other in the cycle the bits change, and the reserved code falls into MODE_SIMPLE. Within a mode, each cell takes one of four roles:

- ROLE_REG: a registered output.
- ROLE_COMB_PT: a combinational output enabled by its product term.
- ROLE_COMB_ON: a combinational output that is always enabled.
- ROLE_INPUT: a pin that is never driven.

Two dedicated pins change meaning with the mode. `dpin_clk` clocks the cell flip-flops, and `dpin_oe_n` is an active-low output enable. In complex mode both become plain inputs that reach the array through the feedback slots of the two outermost cells. In simple mode, feedback is taken from the neighbouring pin, toward the centre of the row.

Top module: `pld_olmc_array`

## Requirements
- R1: Mode encoding is {cfg_syn,cfg_ac0}: 2'b10 selects simple, 2'b11 selects complex and 2'b01 selects registered. The reserved code 2'b00 behaves exactly as simple.
- R2: Every combinational output drives pin_out[i] = sop[i] XOR cfg_xor[i], so cfg_xor[i]=1 inverts the output.
- R3: In registered mode, a cell with cfg_ac1[i]=0 captures sop[i] XOR cfg_xor[i] into its flip-flop on each rising edge of dpin_clk. Its pin_out[i] and fb[i] both show the flip-flop state. In other modes or roles, the flip-flop holds its value.
- R4: In registered mode, a cell with cfg_ac1[i]=0 has pin_oe[i] = NOT dpin_oe_n.
- R5: In registered mode, a cell with cfg_ac1[i]=1 is combinational, with pin_oe[i] = oe_pt[i] and fb[i] = pin_in[i].
- R6: In complex mode, every cell is combinational, with pin_oe[i] = oe_pt[i]. Cells 1 to 6 return fb[i] = pin_in[i].
- R7: In complex mode, fb[0] carries dpin_clk and fb[7] carries dpin_oe_n. Cells 0 and 7 therefore give no feedback of their own pin.
- R8: In simple mode, cells 0 to 2 return fb[i] = pin_in[i+1] and cells 5 to 7 return fb[i] = pin_in[i-1]. The innermost cells 3 and 4 return fb = 0.
- R9: In simple mode, a cell with cfg_ac1[i]=1 is an input with pin_oe[i]=0, and one with cfg_ac1[i]=0 has pin_oe[i]=1. Cells 3 and 4 are always enabled combinational outputs, whatever cfg_ac1 holds.
- R10: While rst_n is low, every cell flip-flop is cleared to 0, asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dpin_clk | input | 1 | Dedicated pin: register clock, or a plain input in complex mode |
| rst_n | input | 1 | Active-low asynchronous clear of the cell flip-flops |
| cfg_syn | input | 1 | Global mode bit (upper bit of mode code) |
| cfg_ac0 | input | 1 | Global mode bit (lower bit of mode code) |
| cfg_xor | input | 8 | Per-cell output polarity, 1 inverts |
| cfg_ac1 | input | 8 | Per-cell role select within the mode |
| sop | input | 8 | Sum-of-products value per cell |
| oe_pt | input | 8 | Output-enable product term per cell |
| dpin_oe_n | input | 1 | Dedicated pin: active-low enable, or a plain input in complex mode |
| pin_in | input | 8 | Value sensed on each cell's pin |
| pin_out | output | 8 | Value each cell drives toward its pin |
| pin_oe | output | 8 | Tri-state enable per pin, 1 drives |
| fb | output | 8 | Feedback bit per cell toward the array |

## Verification
The bench targets the places where routing changes with the mode.

- Simple-mode feedback uses an asymmetric pin pattern and then walking ones. A design that fed a cell its own pin, or crossed the wrong neighbour, would show the pattern unshifted or mirrored.
- The innermost cells are tried with cfg_ac1 set. A design that let them turn into inputs would drop their enables.
- The reserved mode code gets the same stimulus as simple. A decoder that treated it as registered would drive flip-flop state and the dedicated enable instead.
- In registered mode, the bench checks the cycle before and the cycle after the capturing edge, which exposes an output that is transparent or one edge late.
- A mid-run reset with nonzero flip-flops shows whether the clear is asynchronous.
- In complex mode, the dedicated pins are toggled to show whether they, rather than the outer pins, reach the outer feedback slots.

// File: rtl/olmc_pkg.sv
package olmc_pkg;

    typedef enum logic [1:0] {
        MODE_SIMPLE     = 2'd0,
        MODE_COMPLEX    = 2'd1,
        MODE_REGISTERED = 2'd2
    } mode_e;

    typedef enum logic [1:0] {
        ROLE_REG     = 2'd0,
        ROLE_COMB_PT = 2'd1,
        ROLE_COMB_ON = 2'd2,
        ROLE_INPUT   = 2'd3
    } role_e;

endpackage

// File: rtl/olmc_mode_dec.sv
module olmc_mode_dec
    import olmc_pkg::*;
(
    input  logic  syn,
    input  logic  ac0,
    output mode_e mode
);

    // Global mode decode; the unused code 2'b00 folds into simple (R1)
    always_comb begin
        unique case ({syn, ac0})
            2'b10:   mode = MODE_SIMPLE;
            2'b11:   mode = MODE_COMPLEX;
            2'b01:   mode = MODE_REGISTERED;
            default: mode = MODE_SIMPLE;
        endcase
    end

endmodule

// File: rtl/olmc_cell.sv
module olmc_cell
    import olmc_pkg::*;
#(
    parameter bit IS_INNER = 1'b0
) (
    input  logic  clk,
    input  logic  rst_n,
    input  mode_e mode,
    input  logic  ac1,
    input  logic  xorb,
    input  logic  sop,
    input  logic  oe_pt,
    input  logic  oe_n,
    output logic  pin_out,
    output logic  pin_oe,
    output logic  reg_q
);

    role_e role;
    logic  q;
    logic  comb_val;

    // Role of this cell under the current global mode
    always_comb begin
        unique case (mode)
            MODE_REGISTERED: role = ac1 ? ROLE_COMB_PT : ROLE_REG;
            MODE_COMPLEX:    role = ROLE_COMB_PT;
            default:         role = (ac1 && !IS_INNER) ? ROLE_INPUT : ROLE_COMB_ON;
        endcase
    end

    // Cell flip-flop: loads only while acting as a registered output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (role == ROLE_REG) begin
            q <= sop ^ xorb;
        end
    end

    // Pin drive per role
    always_comb begin
        comb_val = sop ^ xorb;
        unique case (role)
            ROLE_REG: begin
                pin_out = q;
                pin_oe  = !oe_n;
            end
            ROLE_COMB_PT: begin
                pin_out = comb_val;
                pin_oe  = oe_pt;
            end
            ROLE_COMB_ON: begin
                pin_out = comb_val;
                pin_oe  = 1'b1;
            end
            ROLE_INPUT: begin
                pin_out = comb_val;
                pin_oe  = 1'b0;
            end
        endcase
    end

    assign reg_q = q;

    // R3: a registered output shows what was loaded on the previous edge
    a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(role == ROLE_REG) && role == ROLE_REG)
            |-> pin_out == $past(sop ^ xorb));

    if (IS_INNER) begin : g_inner_chk
        // R9: innermost cells stay driven in simple mode
        a_r9_inner_driven: assert property (@(posedge clk) disable iff (!rst_n)
            (mode == MODE_SIMPLE) |-> pin_oe);
    end

endmodule

// File: rtl/olmc_fb_route.sv
module olmc_fb_route
    import olmc_pkg::*;
#(
    parameter int N_CELLS = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  mode_e              mode,
    input  logic [N_CELLS-1:0] ac1,
    input  logic [N_CELLS-1:0] q,
    input  logic [N_CELLS-1:0] pin_in,
    input  logic               dpin_a,
    input  logic               dpin_b,
    output logic [N_CELLS-1:0] fb
);

    localparam int HALF = N_CELLS / 2;

    for (genvar i = 0; i < N_CELLS; i++) begin : g_route
        localparam bit IS_INNER = (i == HALF - 1) || (i == HALF);
        localparam bit IS_OUT_A = (i == 0);
        localparam bit IS_OUT_B = (i == N_CELLS - 1);
        localparam int NEIGH    = (i < HALF) ? i + 1 : i - 1;
        logic fb_bit;

        always_comb begin
            unique case (mode)
                MODE_REGISTERED: fb_bit = ac1[i] ? pin_in[i] : q[i];
                MODE_COMPLEX:    fb_bit = IS_OUT_A ? dpin_a :
                                          (IS_OUT_B ? dpin_b : pin_in[i]);
                default:         fb_bit = IS_INNER ? 1'b0 : pin_in[NEIGH];
            endcase
        end

        assign fb[i] = fb_bit;
    end

    // R7: dedicated pins occupy the outer feedback slots in complex mode
    a_r7_dedicated_fb: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_COMPLEX) |-> (fb[0] == dpin_a && fb[N_CELLS-1] == dpin_b));

    // R8: innermost cells return no feedback in simple mode
    a_r8_inner_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SIMPLE) |-> (fb[HALF-1] == 1'b0 && fb[HALF] == 1'b0));

endmodule

// File: rtl/pld_olmc_array.sv
module pld_olmc_array
    import olmc_pkg::*;
#(
    parameter int N_CELLS = 8
) (
    input  logic               dpin_clk,
    input  logic               rst_n,
    input  logic               cfg_syn,
    input  logic               cfg_ac0,
    input  logic [N_CELLS-1:0] cfg_xor,
    input  logic [N_CELLS-1:0] cfg_ac1,
    input  logic [N_CELLS-1:0] sop,
    input  logic [N_CELLS-1:0] oe_pt,
    input  logic               dpin_oe_n,
    input  logic [N_CELLS-1:0] pin_in,
    output logic [N_CELLS-1:0] pin_out,
    output logic [N_CELLS-1:0] pin_oe,
    output logic [N_CELLS-1:0] fb
);

    localparam int HALF = N_CELLS / 2;

    mode_e              mode;
    logic [N_CELLS-1:0] cell_q;

    olmc_mode_dec u_dec (
        .syn  (cfg_syn),
        .ac0  (cfg_ac0),
        .mode (mode)
    );

    for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
        olmc_cell #(
            .IS_INNER ((i == HALF - 1) || (i == HALF))
        ) u_cell (
            .clk     (dpin_clk),
            .rst_n   (rst_n),
            .mode    (mode),
            .ac1     (cfg_ac1[i]),
            .xorb    (cfg_xor[i]),
            .sop     (sop[i]),
            .oe_pt   (oe_pt[i]),
            .oe_n    (dpin_oe_n),
            .pin_out (pin_out[i]),
            .pin_oe  (pin_oe[i]),
            .reg_q   (cell_q[i])
        );

        // R3: registered feedback equals the registered pin value
        a_r3_fb_matches_out: assert property (@(posedge dpin_clk) disable iff (!rst_n)
            (!cfg_syn && cfg_ac0 && !cfg_ac1[i]) |-> fb[i] == pin_out[i]);

        // R4: registered outputs obey the dedicated active-low enable
        a_r4_reg_enable: assert property (@(posedge dpin_clk) disable iff (!rst_n)
            (!cfg_syn && cfg_ac0 && !cfg_ac1[i]) |-> pin_oe[i] != dpin_oe_n);
    end

    olmc_fb_route #(
        .N_CELLS (N_CELLS)
    ) u_route (
        .clk    (dpin_clk),
        .rst_n  (rst_n),
        .mode   (mode),
        .ac1    (cfg_ac1),
        .q      (cell_q),
        .pin_in (pin_in),
        .dpin_a (dpin_clk),
        .dpin_b (dpin_oe_n),
        .fb     (fb)
    );

    // R6: complex mode enables every pin from its product term
    a_r6_complex_pt: assert property (@(posedge dpin_clk) disable iff (!rst_n)
        (cfg_syn && cfg_ac0) |-> pin_oe == oe_pt);

    // R1: the reserved code keeps the inner cells driven like simple mode
    a_r1_reserved_simple: assert property (@(posedge dpin_clk) disable iff (!rst_n)
        (!cfg_syn && !cfg_ac0) |-> (pin_oe[HALF-1] && pin_oe[HALF]));

endmodule

// File: tb/sim_pld_olmc_array.sv
module sim_pld_olmc_array;

    typedef struct {
        logic [7:0] o;
        logic [7:0] oe;
        logic [7:0] f;
        string      tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       syn = 1'b0;
    logic       ac0 = 1'b1;
    logic [7:0] xr = '0;
    logic [7:0] a1 = '0;
    logic [7:0] sp = '0;
    logic [7:0] opt = '0;
    logic       oe_n = 1'b0;
    logic [7:0] pin_in = '0;
    wire  [7:0] pin_out;
    wire  [7:0] pin_oe;
    wire  [7:0] fb;

    logic [7:0] mq = '0;
    item_t      exp_q[$];
    event       ev_chk;
    int         n_total = 0;
    int         n_fail = 0;
    bit         done = 0;

    always #2 clk = ~clk;

    pld_olmc_array u0 (
        .dpin_clk  (clk),
        .rst_n     (rst_n),
        .cfg_syn   (syn),
        .cfg_ac0   (ac0),
        .cfg_xor   (xr),
        .cfg_ac1   (a1),
        .sop       (sp),
        .oe_pt     (opt),
        .dpin_oe_n (oe_n),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .fb        (fb)
    );

    function automatic int cur_mode();
        if (syn && ac0) return 1;
        if (!syn && ac0) return 2;
        return 0;
    endfunction

    // Bench copy of the flip-flop state, per R3 and R10
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) mq = '0;
        else if (cur_mode() == 2)
            for (int i = 0; i < 8; i++) if (!a1[i]) mq[i] = sp[i] ^ xr[i];
    end

    task automatic push_expect(string tag);
        item_t      it;
        logic [7:0] qv;
        int         md;
        qv = rst_n ? mq : 8'h00;
        md = cur_mode();
        for (int i = 0; i < 8; i++) begin
            logic cv;
            bit   inner;
            cv    = sp[i] ^ xr[i];
            inner = (i == 3) || (i == 4);
            if (md == 2) begin
                if (!a1[i]) begin
                    it.o[i] = qv[i]; it.oe[i] = !oe_n; it.f[i] = qv[i];
                end else begin
                    it.o[i] = cv; it.oe[i] = opt[i]; it.f[i] = pin_in[i];
                end
            end else if (md == 1) begin
                it.o[i]  = cv;
                it.oe[i] = opt[i];
                it.f[i]  = (i == 0) ? clk : ((i == 7) ? oe_n : pin_in[i]);
            end else begin
                it.o[i]  = cv;
                it.oe[i] = inner ? 1'b1 : !a1[i];
                it.f[i]  = inner ? 1'b0 : ((i < 4) ? pin_in[i+1] : pin_in[i-1]);
            end
        end
        it.tag = tag;
        exp_q.push_back(it);
        -> ev_chk;
    endtask

    task automatic drive(string tag, logic r, logic s, logic a, logic [7:0] x,
                         logic [7:0] c1, logic [7:0] d, logic [7:0] pt,
                         logic on, logic [7:0] pi);
        @(negedge clk);
        rst_n = r; syn = s; ac0 = a; xr = x; a1 = c1; sp = d; opt = pt;
        oe_n = on; pin_in = pi;
        push_expect(tag);
    endtask

    // Monitor: pops the scoreboard and compares once outputs settle
    initial begin
        forever begin
            @(ev_chk);
            #1;
            while (exp_q.size() > 0) begin
                item_t e;
                e = exp_q.pop_front();
                n_total++;
                if (pin_out !== e.o || pin_oe !== e.oe || fb !== e.f) begin
                    n_fail++;
                    $display("FAIL %s: out=%h/%h oe=%h/%h fb=%h/%h (actual/expected)",
                             e.tag, pin_out, e.o, pin_oe, e.oe, fb, e.f);
                end
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        // R10: reset state in registered mode
        drive("R10 reset clears", 0, 0, 1, 8'h0F, 8'h00, 8'hA5, 8'h00, 0, 8'h00);
        drive("R10 reset held",   0, 0, 1, 8'h0F, 8'h00, 8'hA5, 8'h00, 0, 8'h00);
        // R3: load on the edge after reset release
        drive("R3 before edge",   1, 0, 1, 8'h0F, 8'h00, 8'hA5, 8'h00, 0, 8'h00);
        drive("R3 after edge",    1, 0, 1, 8'h0F, 8'h00, 8'hA5, 8'h00, 0, 8'h00);
        drive("R3 new data",      1, 0, 1, 8'h00, 8'h00, 8'h3C, 8'h00, 0, 8'h00);
        // R4: dedicated enable high tri-states registered pins
        drive("R4 oe_n high",     1, 0, 1, 8'h00, 8'h00, 8'h3C, 8'hFF, 1, 8'h00);
        // R5: mixed registered and combinational cells
        drive("R5 mixed cells",   1, 0, 1, 8'h00, 8'hF0, 8'h69, 8'h3C, 0, 8'h96);
        drive("R5 mixed again",   1, 0, 1, 8'hAA, 8'hF0, 8'h0F, 8'hC3, 1, 8'h5A);
        // R6, R7: complex mode with dedicated pins toggled
        drive("R6 R7 complex oe_n=1", 1, 1, 1, 8'h00, 8'h00, 8'h33, 8'h5A, 1, 8'h7E);
        drive("R6 R7 complex oe_n=0", 1, 1, 1, 8'h00, 8'hFF, 8'h33, 8'hA5, 0, 8'h81);
        // R2: polarity inversion
        drive("R2 invert all",    1, 1, 1, 8'hFF, 8'h00, 8'h33, 8'hFF, 0, 8'h00);
        drive("R2 invert some",   1, 1, 1, 8'hF0, 8'h00, 8'h55, 8'hFF, 0, 8'h00);
        // R8: simple mode neighbour feedback
        drive("R8 simple fb",     1, 1, 0, 8'h00, 8'h00, 8'h0F, 8'h00, 1, 8'b1011_0010);
        for (int k = 0; k < 8; k++)
            drive("R8 walking one", 1, 1, 0, 8'h00, 8'h00, 8'h00, 8'h00, 0, 8'h01 << k);
        // R9: inputs in simple mode, inner cells forced on
        drive("R9 all ac1 set",   1, 1, 0, 8'h00, 8'hFF, 8'hC3, 8'hFF, 0, 8'h3C);
        drive("R9 alternating",   1, 1, 0, 8'h0F, 8'h55, 8'hC3, 8'h00, 1, 8'hE7);
        // R1: reserved code behaves as simple
        drive("R1 reserved code", 1, 0, 0, 8'h00, 8'hFF, 8'hC3, 8'hFF, 0, 8'h3C);
        drive("R1 reserved alt",  1, 0, 0, 8'h0F, 8'h55, 8'hC3, 8'h00, 1, 8'hE7);
        // R3: flip-flops held outside registered mode, visible on return
        drive("R3 reload",        1, 0, 1, 8'h00, 8'h00, 8'h5A, 8'h00, 0, 8'h00);
        drive("R3 loaded 5A",     1, 1, 0, 8'h00, 8'h00, 8'hFF, 8'h00, 0, 8'h00);
        drive("R3 hold in simple",1, 1, 0, 8'h00, 8'h00, 8'hFF, 8'h00, 0, 8'h00);
        drive("R3 held on return",1, 0, 1, 8'h00, 8'h00, 8'hFF, 8'h00, 0, 8'h00);
        // R10: asynchronous clear mid-run
        drive("R10 async clear",  0, 0, 1, 8'h00, 8'h00, 8'hFF, 8'h00, 0, 8'h00);
        @(negedge clk);
        #2;
        done = 1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule